// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command front end of a parallel NOR flash. It watches bus write cycles, made up of an address, a data word and a one-cycle write strobe, and matches them against unlock-coded command sequences. From these sequences it decides whether the chip answers reads from the cell array, from the identification map, or with program status. It also selects the source of read data.

A completed program sequence produces a one-cycle start pulse. The pulse goes to the program engine together with the latched target address and data. The engine reports back through a busy input and an error input. When the engine drops busy, the decoder returns to array read on its own. While the engine is busy, reads return a status word: one bit is the complement of the written bit 7, one bit toggles on each read, and one bit carries the error flag.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode_o` is 0 (array read), `pgm_start_o` is 0, and `rdata_o` equals `arr_data_i`. Mode encoding: 0 array, 1 autoselect, 2 program.
- R2: The program sequence has four writes. The first is AAh to address 555h, then 55h to 2AAh, then A0h to 555h, then data D to address A. Only `wdata_i[7:0]` and `addr_i[10:0]` are compared. In the cycle after the fourth write, `pgm_start_o` is 1 for exactly one cycle, with `pgm_addr_o`=A, `pgm_data_o`=D and `mode_o`=2.
- R3: The two unlock writes followed by 90h at 555h put the decoder in autoselect (`mode_o`=1). Any number of reads may then follow.
- R4: In autoselect, `rdata_o` is decoded from `addr_i[7:0]` as follows:
  - 00h returns `MFR_ID` and 01h returns `DEV_ID`.
  - 02h returns 0001h if `prot_i[addr_i[AW-1 -: SECT_W]]` is set, else 0000h.
  - 03h returns 0001h when `burst_i` is 1, else 0000h.
  - Any other offset returns 0000h.
- R5: A write of F0h at any address returns a partial sequence (before the program data write) or autoselect to array read.
- R6: A write that does not match the expected next cycle of a sequence aborts it, and the decoder stays in array read.
- R7: In autoselect, every write other than F0h is ignored, and the mode stays 1.
- R8: While programming, writes are ignored, F0h included, unless `pgm_err_i` is 1.
- R9: While programming with `pgm_err_i` = 1, a write of F0h returns the decoder to array read.
- R10: Programming ends, returning to array read, in the first cycle after the start pulse in which `pgm_busy_i` is 0. Outside program mode, `pgm_addr_o` and `pgm_data_o` are 0.
- R11: In program mode, `rdata_o` has the following bits:
  - bit 7 is the inverse of `pgm_data_o[7]`;
  - bit 6 starts at 0 and inverts after each cycle with `re_i` high;
  - bit 5 equals `pgm_err_i`;
  - all other bits are 0.
- R12: In array read and in partial sequences, `rdata_o` equals `arr_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Bus write strobe, one cycle per write |
| re_i | input | 1 | Bus read strobe, one cycle per read |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| arr_data_i | input | DW | Data from the cell array |
| prot_i | input | 2**SECT_W | Per-sector protection flags |
| burst_i | input | 1 | 1 when the read interface is in burst mode |
| pgm_busy_i | input | 1 | Program engine busy |
| pgm_err_i | input | 1 | Program engine error flag |
| rdata_o | output | DW | Read data |
| mode_o | output | 2 | 0 array, 1 autoselect, 2 program |
| pgm_start_o | output | 1 | One-cycle program start pulse |
| pgm_addr_o | output | AW | Latched program address |
| pgm_data_o | output | DW | Latched program data |

## Verification
The program sequence is driven with data words whose bit 7 is both set and clear, so the inverted status bit and the latched data are told apart from a constant. The identification map is swept over every sector, every defined offset and an undefined offset, using an alternating protection pattern and both burst settings, so a wrong sector index or a wrong offset decode shows up. Sequences are broken at each stage, by a wrong unlock word, a wrong command and a reset word, and are then followed by writes that would complete a sequence. This separates a real abort from a stalled partial state. Program mode is hit with a reset write both with and without the error flag, to separate the two reset rules.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {MODE_ARRAY = 2'd0, MODE_AUTO = 2'd1, MODE_PROG = 2'd2} mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_UNL1, ST_UNL2, ST_SETUP, ST_AUTO, ST_PROG} seq_state_e;

  localparam int unsigned   CMD_AW   = 11;
  localparam logic [10:0]   A_UNL1   = 11'h555;
  localparam logic [10:0]   A_UNL2   = 11'h2AA;
  localparam logic [7:0]    D_UNL1   = 8'hAA;
  localparam logic [7:0]    D_UNL2   = 8'h55;
  localparam logic [7:0]    CMD_PGM  = 8'hA0;
  localparam logic [7:0]    CMD_AUTO = 8'h90;
  localparam logic [7:0]    CMD_RST  = 8'hF0;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          err_i,
  output mode_e         mode_o,
  output logic          start_o,
  output logic [AW-1:0] pgm_addr_o,
  output logic [DW-1:0] pgm_data_o
);
  seq_state_e    state_q, state_d;
  logic          start_q, load;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          is_rst, at_a1, at_a2;

  assign is_rst = wdata_i[7:0] == CMD_RST;
  assign at_a1  = addr_i[CMD_AW-1:0] == A_UNL1;
  assign at_a2  = addr_i[CMD_AW-1:0] == A_UNL2;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (we_i && at_a1 && wdata_i[7:0] == D_UNL1) state_d = ST_UNL1;
      ST_UNL1:  if (we_i) state_d = (at_a2 && wdata_i[7:0] == D_UNL2) ? ST_UNL2 : ST_IDLE;
      ST_UNL2:  if (we_i) begin
        if (at_a1 && wdata_i[7:0] == CMD_PGM)       state_d = ST_SETUP;
        else if (at_a1 && wdata_i[7:0] == CMD_AUTO) state_d = ST_AUTO;
        else                                        state_d = ST_IDLE;
      end
      ST_SETUP: if (we_i) begin
        if (is_rst) state_d = ST_IDLE;
        else begin
          state_d = ST_PROG;
          load    = 1'b1;
        end
      end
      ST_AUTO:  if (we_i && is_rst) state_d = ST_IDLE;
      ST_PROG:  if ((we_i && is_rst && err_i) || (!start_q && !busy_i)) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= load;
      if (load) begin
        addr_q <= addr_i;
        data_q <= wdata_i;
      end else if (state_d != ST_PROG) begin
        addr_q <= '0;
        data_q <= '0;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_AUTO: mode_o = MODE_AUTO;
      ST_PROG: mode_o = MODE_PROG;
      default: mode_o = MODE_ARRAY;
    endcase
  end

  assign start_o    = start_q;
  assign pgm_addr_o = addr_q;
  assign pgm_data_o = data_q;

  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  a_r2_start_in_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> state_q == ST_PROG);
  a_r10_latch_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_PROG |-> (addr_q == '0 && data_q == '0));
  a_r10_exit_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && !start_q && !busy_i) |=> state_q == ST_IDLE);
  a_r8_prog_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && (start_q || busy_i) && !(we_i && is_rst && err_i)) |=> state_q == ST_PROG);
  a_r7_auto_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AUTO && !(we_i && is_rst)) |=> state_q == ST_AUTO);
  a_r5_reset_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_rst && state_q != ST_PROG) |=> state_q == ST_IDLE);
endmodule

// File: rtl/fcd_id_map.sv
module fcd_id_map #(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 16,
  parameter int unsigned SECT_W = 2,
  parameter logic [DW-1:0] MFR_ID = 16'h0051,
  parameter logic [DW-1:0] DEV_ID = 16'h22A7
) (
  input  logic [AW-1:0]          addr_i,
  input  logic [(1<<SECT_W)-1:0] prot_i,
  input  logic                   burst_i,
  output logic [DW-1:0]          id_o
);
  logic [SECT_W-1:0] sect;
  assign sect = addr_i[AW-1 -: SECT_W];

  always_comb begin
    id_o = '0;
    unique case (addr_i[7:0])
      8'h00:   id_o = MFR_ID;
      8'h01:   id_o = DEV_ID;
      8'h02:   id_o[0] = prot_i[sect];
      8'h03:   id_o[0] = burst_i;
      default: id_o = '0;
    endcase
  end
endmodule

// File: rtl/fcd_status.sv
module fcd_status #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_i,
  input  logic          re_i,
  input  logic          data7_i,
  input  logic          err_i,
  output logic [DW-1:0] status_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_q <= 1'b0;
    else if (!prog_i) tog_q <= 1'b0;
    else if (re_i)    tog_q <= ~tog_q;
  end

  always_comb begin
    status_o    = '0;
    status_o[7] = ~data7_i;
    status_o[6] = tog_q;
    status_o[5] = err_i;
  end

  a_r11_toggle_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && re_i) |=> (!prog_i || tog_q != $past(tog_q)));
  a_r11_toggle_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && !re_i) |=> (!prog_i || $stable(tog_q)));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned   AW     = 16,
  parameter int unsigned   DW     = 16,
  parameter int unsigned   SECT_W = 2,
  parameter logic [DW-1:0] MFR_ID = 16'h0051,
  parameter logic [DW-1:0] DEV_ID = 16'h22A7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   re_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [DW-1:0]          arr_data_i,
  input  logic [(1<<SECT_W)-1:0] prot_i,
  input  logic                   burst_i,
  input  logic                   pgm_busy_i,
  input  logic                   pgm_err_i,
  output logic [DW-1:0]          rdata_o,
  output logic [1:0]             mode_o,
  output logic                   pgm_start_o,
  output logic [AW-1:0]          pgm_addr_o,
  output logic [DW-1:0]          pgm_data_o
);
  mode_e         mode;
  logic [DW-1:0] id_word, stat_word;

  fcd_seq #(.AW(AW), .DW(DW)) i_seq (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .busy_i(pgm_busy_i), .err_i(pgm_err_i),
    .mode_o(mode), .start_o(pgm_start_o),
    .pgm_addr_o, .pgm_data_o
  );

  fcd_id_map #(.AW(AW), .DW(DW), .SECT_W(SECT_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) i_id (
    .addr_i, .prot_i, .burst_i, .id_o(id_word)
  );

  fcd_status #(.DW(DW)) i_stat (
    .clk_i, .rst_ni, .prog_i(mode == MODE_PROG), .re_i,
    .data7_i(pgm_data_o[7]), .err_i(pgm_err_i), .status_o(stat_word)
  );

  always_comb begin
    unique case (mode)
      MODE_AUTO: rdata_o = id_word;
      MODE_PROG: rdata_o = stat_word;
      default:   rdata_o = arr_data_i;
    endcase
  end

  assign mode_o = mode;

  a_r12_array_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_ARRAY |-> rdata_o == arr_data_i);
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int unsigned AW = 16, DW = 16, SECT_W = 2;
  localparam logic [15:0] MFR = 16'h0051, DEV = 16'h22A7;
  localparam int BUSY_LEN = 20;

  logic clk = 0, rst_n = 0, we = 0, re = 0, burst = 0, err = 0, hold = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, arr_data, rdata, pgm_data;
  logic [3:0] prot = 4'b1010;
  logic [1:0] mode;
  logic start, busy;
  logic [AW-1:0] pgm_addr;
  int busy_cnt = 0, checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign arr_data = addr ^ 16'h5A5A;
  assign busy = busy_cnt != 0 || hold;

  always @(posedge clk) begin
    if (start) busy_cnt <= BUSY_LEN;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  flash_cmd_decoder #(.AW(AW), .DW(DW), .SECT_W(SECT_W), .MFR_ID(MFR), .DEV_ID(DEV)) i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .arr_data_i(arr_data), .prot_i(prot), .burst_i(burst), .pgm_busy_i(busy), .pgm_err_i(err),
    .rdata_o(rdata), .mode_o(mode), .pgm_start_o(start), .pgm_addr_o(pgm_addr), .pgm_data_o(pgm_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    addr = a; re = 1;
    #1 chk(tag, rdata, exp);
    @(negedge clk);
    re = 0;
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  function automatic logic [15:0] stat(input logic [15:0] d, input logic t, input logic e);
    stat = '0;
    stat[7] = ~d[7];
    stat[6] = t;
    stat[5] = e;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pdata [4] = '{16'h0080, 16'h007F, 16'hC3A5, 16'h1234};
    logic [15:0] paddr [4] = '{16'h0000, 16'h0555, 16'hFFFF, 16'h8ABC};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 start", start, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mode after release", mode, 0);
    for (int i = 0; i < 4; i++) rd(16'h1111 * i, (16'h1111 * i) ^ 16'h5A5A, "R12 array read");

    // R2 R11 R8 R10 program sweep
    for (int k = 0; k < 4; k++) begin
      unlock();
      rd(16'h0123, 16'h0123 ^ 16'h5A5A, "R12 partial read");
      wr(16'h0555, 16'h00A0);
      chk("R2 no start before data", start, 0);
      wr(paddr[k], pdata[k]);
      chk("R2 start pulse", start, 1);
      chk("R2 mode", mode, 2);
      chk("R2 addr", pgm_addr, paddr[k]);
      chk("R2 data", pgm_data, pdata[k]);
      @(negedge clk);
      chk("R2 start one cycle", start, 0);
      for (int r = 0; r < 3; r++) rd(16'h0000, stat(pdata[k], r[0], 1'b0), "R11 status read");
      wr(16'h0555, 16'h00F0);
      chk("R8 reset ignored", mode, 2);
      wr(16'h0555, 16'h00AA);
      chk("R8 write ignored", mode, 2);
      rd(16'h0000, stat(pdata[k], 1'b1, 1'b0), "R11 toggle kept over writes");
      for (int w = 0; w < 100 && mode != 0; w++) @(negedge clk);
      chk("R10 back to array", mode, 0);
      chk("R10 addr cleared", pgm_addr, 0);
      chk("R10 data cleared", pgm_data, 0);
      chk("R10 busy low at exit", busy, 0);
    end

    // R3 R4 R7 R5 autoselect sweep
    for (int b = 0; b < 2; b++) begin
      burst = b[0];
      unlock();
      wr(16'h0555, 16'h0090);
      chk("R3 autoselect mode", mode, 1);
      for (int s = 0; s < 4; s++) begin
        logic [15:0] base;
        base = 16'(s) << 14;
        rd(base | 16'h0000, MFR, "R4 manufacturer");
        rd(base | 16'h0001, DEV, "R4 device");
        rd(base | 16'h0002, {15'b0, prot[s]}, "R4 protect");
        rd(base | 16'h0003, {15'b0, b[0]}, "R4 burst");
        rd(base | 16'h0005, 16'h0000, "R4 undefined");
      end
      wr(16'h0555, 16'h00AA);
      wr(16'h0555, 16'h00A0);
      wr(16'h0100, 16'h1234);
      chk("R7 autoselect held", mode, 1);
      chk("R7 no start", start, 0);
      rd(16'h0001, DEV, "R7 id after ignored writes");
      wr(16'h1234 + 16'(b), 16'h00F0);
      chk("R5 reset leaves autoselect", mode, 0);
      rd(16'h0001, 16'h0001 ^ 16'h5A5A, "R5 array after reset");
    end
    burst = 0;

    // R6 abort at each stage, then writes that would complete a sequence
    wr(16'h0555, 16'h00AA); wr(16'h02AB, 16'h0055);
    wr(16'h0555, 16'h0090);
    chk("R6 bad second unlock", mode, 0);
    unlock(); wr(16'h0555, 16'h0080);
    wr(16'h0555, 16'h00A0); wr(16'h0200, 16'h0042);
    chk("R6 bad command mode", mode, 0);
    chk("R6 bad command no start", start, 0);
    unlock(); wr(16'h0554, 16'h00A0);
    wr(16'h0300, 16'h0043);
    chk("R6 command wrong address", start, 0);

    // R5 reset inside partial sequences
    wr(16'h0555, 16'h00AA); wr(16'h7777, 16'h00F0);
    wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0090);
    chk("R5 reset after first unlock", mode, 0);
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h4000, 16'h00F0);
    chk("R5 reset after setup no start", start, 0);
    chk("R5 reset after setup mode", mode, 0);
    wr(16'h0400, 16'h0055);
    chk("R5 setup cancelled", start, 0);

    // R9 error recovery
    hold = 1;
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h0600, 16'h0011);
    chk("R9 program started", mode, 2);
    err = 1;
    @(negedge clk);
    rd(16'h0000, stat(16'h0011, 1'b0, 1'b1), "R11 error bit");
    wr(16'h0000, 16'h0033);
    chk("R9 non-reset ignored under error", mode, 2);
    wr(16'h2345, 16'h00F0);
    chk("R9 reset under error", mode, 0);
    chk("R10 latch cleared after error reset", pgm_data, 0);
    hold = 0; err = 0;
    repeat (BUSY_LEN + 2) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule